// File: doc/BRIEF.md
# UART Receive Queue Controller

This block sits behind the receiver shift register of a 16550-class UART. Every finished character arrives as a one-cycle strobe with its byte. In queued mode the byte goes into a 16-entry circular buffer. The data-ready interrupt follows a programmable fill threshold. Characters that arrive while the buffer is full are counted as overrun and thrown away, so the stored bytes stay as they were. A character-time watchdog reports bytes that sit below the threshold for too long. In single-register mode the queue is bypassed: one holding register keeps the most recent byte.

The block also generates the 16x oversampling tick from a 16-bit divisor. A divisor of zero means 65536. The same tick paces the character-time watchdog. Software sees the block only through these ports: a data-register read strobe, a line-status read strobe, a control write (enable, flush, threshold) and a divisor write.

Top module: `uart_rx_queue`

## Requirements
- R1: After reset the divisor is 96 (baudTick pulses once every 96 cycles), single-register mode is selected with threshold 1, lineStatus is 0 and all three interrupts are low.
- R2: baudTick is high for one cycle in every D cycles, where D is the divisor; divisor value 0 gives a period of 65536. A divisor write restarts the count, so the first tick comes D cycles after the write.
- R3: In queued mode (control bit 0 = 1) up to 16 bytes are held, and data-register reads return them oldest first on dataOut. dataOut shows the oldest byte before the read strobe is applied.
- R4: In queued mode a character that arrives while 16 bytes are held sets lineStatus bit 1 (overrun) and intLineStatus, and is dropped; the 16 stored bytes read back unchanged.
- R5: Control bits 7:6 select the threshold: 00 = 1, 01 = 4, 10 = 8, 11 = 14 bytes. intRxData is high while the held count is at or above the threshold. lineStatus bit 0 (data ready) is set when a stored character brings the count up to the threshold.
- R6: A read that drops the count below the threshold lowers intRxData. lineStatus bit 0 stays set while any byte remains and clears when the read empties the queue.
- R7: Each accepted character, and each read that leaves bytes behind, restarts a watchdog of 4 character times (640 baud ticks). If it expires with bytes held, intCharTimeout and lineStatus bit 0 are set. The next data-register read clears intCharTimeout.
- R8: A control write with bit 1 set, or with bit 0 changed, empties the queue and clears data ready, intRxData and intCharTimeout. The next character stored is the next one read.
- R9: In single-register mode a character sets lineStatus bit 0 and intRxData, and a data-register read returns the latest byte and clears both.
- R10: In single-register mode a character that arrives while lineStatus bit 0 is set sets the overrun bit and intLineStatus. A line-status read (lsrRead) clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| charValid | input | 1 | One-cycle strobe: a character is complete |
| charData | input | 8 | Completed character |
| dataRead | input | 1 | Data-register read strobe (pops in queued mode) |
| dataOut | output | 8 | Oldest held byte (queued) or holding register |
| lsrRead | input | 1 | Line-status read strobe, clears overrun |
| fcrWrite | input | 1 | Control write strobe |
| fcrData | input | 8 | Control value: bit 0 enable queue, bit 1 flush, bits 7:6 threshold |
| divWrite | input | 1 | Divisor write strobe |
| divData | input | 16 | New divisor, 0 means 65536 |
| baudTick | output | 1 | 16x oversampling tick |
| lineStatus | output | 2 | Bit 0 data ready, bit 1 overrun |
| intRxData | output | 1 | Receive-data interrupt |
| intCharTimeout | output | 1 | Character-timeout interrupt |
| intLineStatus | output | 1 | Line-status (overrun) interrupt |

## Verification
If a pointer or the full flag goes wrong, it shows on dataOut at the next read: a byte out of order, a repeated byte, or the dropped 17th byte appearing. It also shows in a data-ready bit that does not clear once the last expected byte has been read. A wrong threshold decode or a wrong count changes intRxData in the same cycle that the count crosses the threshold. A watchdog that is not restarted, or not stopped, shows as intCharTimeout rising far from 640 ticks after the last push or read, or rising with nothing stored. A wrong divisor reload shows up as a wrong baudTick period within one period.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef struct packed {
    logic push;      // store charData into the queue
    logic pop;       // retire the oldest queue entry
    logic flush;     // empty the queue
    logic loadHold;  // capture charData in the holding register
  } rxq_strobe_t;

  // threshold select from control bits 7:6
  function automatic int unsigned trigDepth(input logic [1:0] sel);
    case (sel)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/rxq_baudgen.sv
module rxq_baudgen #(
  parameter int DIV_W   = 16,
  parameter int DEF_DIV = 96
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             divWrite,
  input  logic [DIV_W-1:0] divData,
  output logic             baudTick
);

  logic [DIV_W-1:0] divReg;
  logic [DIV_W-1:0] cnt;

  // a divisor of zero wraps to all ones, which gives a period of 2**DIV_W
  assign baudTick = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divReg <= DIV_W'(DEF_DIV);
      cnt    <= DIV_W'(DEF_DIV - 1);
    end else if (divWrite) begin
      divReg <= divData;
      cnt    <= divData - DIV_W'(1);
    end else if (baudTick) begin
      cnt <= divReg - DIV_W'(1);
    end else begin
      cnt <= cnt - DIV_W'(1);
    end
  end

  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (baudTick && !divWrite && divReg != DIV_W'(1)) |=> !baudTick);

endmodule

// File: rtl/rxq_datapath.sv
module rxq_datapath import rxq_pkg::*; #(
  parameter  int DEPTH = 16,
  parameter  int DW    = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int LW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  rxq_strobe_t   strobe,
  input  logic          fifoMode,
  input  logic [DW-1:0] inByte,
  output logic [DW-1:0] outByte,
  output logic [LW-1:0] level,
  output logic          full
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr;
  logic [AW-1:0] rdPtr;
  logic [DW-1:0] holdReg;

  assign level   = full ? LW'(DEPTH) : {1'b0, AW'(wrPtr - rdPtr)};
  assign outByte = fifoMode ? mem[rdPtr] : holdReg;

  always_ff @(posedge clk) begin
    if (strobe.push) mem[wrPtr] <= inByte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      full    <= 1'b0;
      holdReg <= '0;
    end else begin
      if (strobe.loadHold) holdReg <= inByte;
      if (strobe.flush) begin
        wrPtr <= '0;
        rdPtr <= '0;
        full  <= 1'b0;
      end else begin
        if (strobe.push) wrPtr <= AW'(wrPtr + 1'b1);
        if (strobe.pop)  rdPtr <= AW'(rdPtr + 1'b1);
        if (strobe.pop)       full <= 1'b0;
        else if (strobe.push) full <= (AW'(wrPtr + 1'b1) == rdPtr);
      end
    end
  end

  // R4
  push_not_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.push |-> !full);

  // R3
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.pop |-> (level != '0));

  // R3
  full_ptrs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (wrPtr == rdPtr));

  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.flush |=> (level == '0));

endmodule

// File: rtl/rxq_control.sv
module rxq_control import rxq_pkg::*; #(
  parameter  int DEPTH         = 16,
  parameter  int BITS_PER_CHAR = 10,
  parameter  int OVERSAMPLE    = 16,
  parameter  int TIMEOUT_CHARS = 4,
  localparam int LW            = $clog2(DEPTH) + 1,
  localparam int TMO_TICKS     = TIMEOUT_CHARS * BITS_PER_CHAR * OVERSAMPLE,
  localparam int TW            = $clog2(TMO_TICKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          charValid,
  input  logic          dataRead,
  input  logic          lsrRead,
  input  logic          fcrWrite,
  input  logic [7:0]    fcrData,
  input  logic          baudTick,
  input  logic [LW-1:0] level,
  input  logic          full,
  output rxq_strobe_t   strobe,
  output logic          fifoMode,
  output logic [1:0]    lineStatus,
  output logic          intRxData,
  output logic          intCharTimeout,
  output logic          intLineStatus
);

  logic [7:0]    fcrReg;
  logic          readyReg;
  logic          overrunReg;
  logic          tmoReg;
  logic          tmrRun;
  logic [TW-1:0] tmrCnt;
  logic          clearEvt;
  logic          overrunEvt;
  logic          expire;
  logic [LW-1:0] trigLevel;
  logic [LW-1:0] levelAfter;

  assign fifoMode  = fcrReg[0];
  assign trigLevel = LW'(trigDepth(fcrReg[7:6]));

  assign clearEvt = fcrWrite && (fcrData[1] || (fcrData[0] != fcrReg[0]));

  always_comb begin
    strobe          = '0;
    strobe.flush    = clearEvt;
    strobe.push     = charValid && fifoMode && !full && !clearEvt;
    strobe.pop      = dataRead && fifoMode && (level != '0) && !clearEvt;
    strobe.loadHold = charValid && !fifoMode;
  end

  assign overrunEvt = charValid && (fifoMode ? full : readyReg);
  assign levelAfter = level + LW'(strobe.push) - LW'(strobe.pop);
  assign expire     = tmrRun && baudTick && (tmrCnt == TW'(TMO_TICKS - 1));

  assign lineStatus     = {overrunReg, readyReg};
  assign intRxData      = fifoMode ? (level >= trigLevel) : readyReg;
  assign intCharTimeout = tmoReg;
  assign intLineStatus  = overrunReg;

  // control register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        fcrReg <= 8'h06;
    else if (fcrWrite) fcrReg <= fcrData;
  end

  // data-ready flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      readyReg <= 1'b0;
    end else if (clearEvt) begin
      readyReg <= 1'b0;
    end else if (fifoMode) begin
      if (strobe.push && levelAfter >= trigLevel)    readyReg <= 1'b1;
      else if (strobe.pop && levelAfter == '0)        readyReg <= 1'b0;
      else if (expire && level != '0)                 readyReg <= 1'b1;
    end else begin
      if (charValid)     readyReg <= 1'b1;
      else if (dataRead) readyReg <= 1'b0;
    end
  end

  // overrun flag, cleared by a line-status read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          overrunReg <= 1'b0;
    else if (overrunEvt) overrunReg <= 1'b1;
    else if (lsrRead)    overrunReg <= 1'b0;
  end

  // character-time watchdog
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmrRun <= 1'b0;
      tmrCnt <= '0;
    end else if (clearEvt || !fifoMode) begin
      tmrRun <= 1'b0;
      tmrCnt <= '0;
    end else if (strobe.push || (strobe.pop && levelAfter != '0)) begin
      tmrRun <= 1'b1;
      tmrCnt <= '0;
    end else if (strobe.pop || expire) begin
      tmrRun <= 1'b0;
      tmrCnt <= '0;
    end else if (tmrRun && baudTick) begin
      tmrCnt <= TW'(tmrCnt + 1'b1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                        tmoReg <= 1'b0;
    else if (clearEvt || (dataRead && fifoMode))       tmoReg <= 1'b0;
    else if (expire && !strobe.push && level != '0)    tmoReg <= 1'b1;
  end

  // R4
  fifo_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (charValid && fifoMode && full) |=> lineStatus[1]);

  // R10
  hold_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (charValid && !fifoMode && readyReg && !fcrWrite) |=> intLineStatus);

  // R5
  trig_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.push && !strobe.pop && (level + 1'b1) == trigLevel) |=> readyReg);

  // R6
  drain_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.pop && !strobe.push && level == LW'(1)) |=> !readyReg);

  // R7
  tmo_has_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    intCharTimeout |-> (level != '0));

endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue import rxq_pkg::*; #(
  parameter int DEPTH         = 16,
  parameter int DW            = 8,
  parameter int DIV_W         = 16,
  parameter int DEF_DIV       = 96,
  parameter int BITS_PER_CHAR = 10,
  parameter int OVERSAMPLE    = 16,
  parameter int TIMEOUT_CHARS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             charValid,
  input  logic [DW-1:0]    charData,
  input  logic             dataRead,
  output logic [DW-1:0]    dataOut,
  input  logic             lsrRead,
  input  logic             fcrWrite,
  input  logic [7:0]       fcrData,
  input  logic             divWrite,
  input  logic [DIV_W-1:0] divData,
  output logic             baudTick,
  output logic [1:0]       lineStatus,
  output logic             intRxData,
  output logic             intCharTimeout,
  output logic             intLineStatus
);

  localparam int LW = $clog2(DEPTH) + 1;

  rxq_strobe_t   strobe;
  logic          fifoMode;
  logic [LW-1:0] level;
  logic          full;

  rxq_baudgen #(.DIV_W(DIV_W), .DEF_DIV(DEF_DIV)) u_baud (
    .clk(clk), .rst_n(rst_n), .divWrite(divWrite), .divData(divData),
    .baudTick(baudTick)
  );

  rxq_control #(
    .DEPTH(DEPTH), .BITS_PER_CHAR(BITS_PER_CHAR),
    .OVERSAMPLE(OVERSAMPLE), .TIMEOUT_CHARS(TIMEOUT_CHARS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .charValid(charValid), .dataRead(dataRead),
    .lsrRead(lsrRead), .fcrWrite(fcrWrite), .fcrData(fcrData),
    .baudTick(baudTick), .level(level), .full(full), .strobe(strobe),
    .fifoMode(fifoMode), .lineStatus(lineStatus), .intRxData(intRxData),
    .intCharTimeout(intCharTimeout), .intLineStatus(intLineStatus)
  );

  rxq_datapath #(.DEPTH(DEPTH), .DW(DW)) u_data (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .fifoMode(fifoMode),
    .inByte(charData), .outByte(dataOut), .level(level), .full(full)
  );

endmodule

// File: tb/tb_uart_rx_queue.sv
module tb_uart_rx_queue;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        charValid = 1'b0;
  logic [7:0]  charData = '0;
  logic        dataRead = 1'b0;
  logic [7:0]  dataOut;
  logic        lsrRead = 1'b0;
  logic        fcrWrite = 1'b0;
  logic [7:0]  fcrData = '0;
  logic        divWrite = 1'b0;
  logic [15:0] divData = '0;
  logic        baudTick;
  logic [1:0]  lineStatus;
  logic        intRxData;
  logic        intCharTimeout;
  logic        intLineStatus;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  uart_rx_queue dut (
    .clk(clk), .rst_n(rst_n), .charValid(charValid), .charData(charData),
    .dataRead(dataRead), .dataOut(dataOut), .lsrRead(lsrRead),
    .fcrWrite(fcrWrite), .fcrData(fcrData), .divWrite(divWrite),
    .divData(divData), .baudTick(baudTick), .lineStatus(lineStatus),
    .intRxData(intRxData), .intCharTimeout(intCharTimeout),
    .intLineStatus(intLineStatus)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // all stimulus tasks start and end at a falling edge
  task automatic putChar(input logic [7:0] b);
    charValid = 1'b1; charData = b;
    @(negedge clk);
    charValid = 1'b0;
  endtask

  task automatic getChar(output logic [7:0] b);
    b = dataOut; dataRead = 1'b1;
    @(negedge clk);
    dataRead = 1'b0;
  endtask

  task automatic setFcr(input logic [7:0] v);
    fcrWrite = 1'b1; fcrData = v;
    @(negedge clk);
    fcrWrite = 1'b0;
  endtask

  task automatic clearLsr();
    lsrRead = 1'b1;
    @(negedge clk);
    lsrRead = 1'b0;
  endtask

  // writes the divisor and returns cycles until the first tick
  task automatic setDiv(input logic [15:0] v, output int n);
    divWrite = 1'b1; divData = v;
    @(negedge clk);
    divWrite = 1'b0;
    n = 1;
    while (!baudTick && n < 70000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic testReset();
    int n;
    chk("R1 lineStatus", lineStatus, 0);
    chk("R1 ints", {intRxData, intCharTimeout, intLineStatus}, 0);
    n = 0;
    while (!baudTick && n < 200) begin @(negedge clk); n++; end
    n = 0;
    do begin @(negedge clk); n++; end while (!baudTick && n < 200);
    chk("R1 R2 default tick period", n, 96);
  endtask

  task automatic testHold();
    logic [7:0] b;
    putChar(8'hA5);
    chk("R9 ready", lineStatus[0], 1);
    chk("R9 intRxData", intRxData, 1);
    getChar(b);
    chk("R9 data", b, 8'hA5);
    chk("R9 ready cleared", {lineStatus[0], intRxData}, 0);
    putChar(8'h11);
    chk("R10 no overrun yet", lineStatus[1], 0);
    putChar(8'h22);
    chk("R10 overrun", lineStatus[1], 1);
    chk("R10 intLineStatus", intLineStatus, 1);
    getChar(b);
    chk("R9 latest byte", b, 8'h22);
    clearLsr();
    chk("R10 lsrRead clears", {lineStatus[1], intLineStatus}, 0);
  endtask

  task automatic testQueue();
    logic [7:0] b;
    setFcr(8'h01);
    chk("R8 mode change empties", lineStatus[0], 0);
    for (int i = 0; i < 16; i++) begin
      putChar(8'h30 + 8'(i));
      if (i == 0) chk("R5 threshold 1", {lineStatus[0], intRxData}, 3);
    end
    chk("R4 no overrun at 16", lineStatus[1], 0);
    putChar(8'hEE);
    chk("R4 overrun", lineStatus[1], 1);
    chk("R4 intLineStatus", intLineStatus, 1);
    for (int i = 0; i < 16; i++) begin
      getChar(b);
      chk("R3 R4 order", b, 8'h30 + i);
    end
    chk("R6 empty clears ready", {lineStatus[0], intRxData}, 0);
    clearLsr();
  endtask

  task automatic testTriggers();
    logic [7:0] b;
    int depth;
    for (int s = 1; s < 4; s++) begin
      depth = (s == 1) ? 4 : (s == 2) ? 8 : 14;
      setFcr({2'(s), 6'b000011});
      for (int k = 0; k < depth - 1; k++) putChar(8'(k));
      chk("R5 below threshold", {lineStatus[0], intRxData}, 0);
      putChar(8'hF0);
      chk("R5 at threshold", {lineStatus[0], intRxData}, 3);
      getChar(b);
      chk("R6 first byte", b, 0);
      chk("R6 int drops, ready stays", {lineStatus[0], intRxData}, 2);
      for (int k = 1; k < depth; k++) getChar(b);
      chk("R6 last byte", b, 8'hF0);
      chk("R6 drained", lineStatus[0], 0);
    end
  endtask

  task automatic testTimeout();
    logic [7:0] b;
    int n;
    setDiv(16'd1, n);
    setFcr(8'hC3);
    putChar(8'h71);
    putChar(8'h72);
    repeat (600) @(negedge clk);
    chk("R7 not yet", {intCharTimeout, lineStatus[0]}, 0);
    repeat (100) @(negedge clk);
    chk("R7 expired", {intCharTimeout, lineStatus[0]}, 3);
    getChar(b);
    chk("R7 data", b, 8'h71);
    chk("R7 read clears timeout", {intCharTimeout, lineStatus[0]}, 1);
    repeat (700) @(negedge clk);
    chk("R7 restarted by read", intCharTimeout, 1);
    getChar(b);
    chk("R7 second byte", b, 8'h72);
    chk("R7 empty", {intCharTimeout, lineStatus[0]}, 0);
  endtask

  task automatic testFlush();
    logic [7:0] b;
    setFcr(8'h03);
    putChar(8'h01); putChar(8'h02); putChar(8'h03);
    chk("R8 before flush", lineStatus[0], 1);
    setFcr(8'h03);
    chk("R8 flushed", {lineStatus[0], intRxData, intCharTimeout}, 0);
    putChar(8'h5A);
    getChar(b);
    chk("R8 next byte after flush", b, 8'h5A);
    chk("R8 empty again", lineStatus[0], 0);
  endtask

  task automatic testDivisor();
    int n;
    setDiv(16'd5, n);
    chk("R2 divisor 5", n, 5);
    setDiv(16'd0, n);
    chk("R2 divisor 0 means 65536", n, 65536);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testHold();
    testQueue();
    testTriggers();
    testTimeout();
    testFlush();
    testDivisor();
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

endmodule